// File: doc/BRIEF.md
# Banked Byte Data Memory with Access Window

This block is the byte-wide data store of a small controller core. A location is selected by a short offset carried in each instruction, plus an access bit that picks how the offset is widened into a full address. When the access bit is 0, the offset falls into a fixed 256-byte window. The lower half of that window reaches the bottom of the memory. The upper half reaches the top of the memory, where the peripheral registers live. When the access bit is 1, a 4-bit bank register supplies the upper address bits, so the whole space can be reached one 256-byte bank at a time.

The block has one combinational read port and one clocked write port. Each port resolves its own address. Addresses in the top half-bank are the special-function region. The block does not store them: each port raises a hit flag there, so outside peripheral logic can serve the access. The internal RAM ignores writes to that region and reads it as zero. The bank register has its own load strobe.

Top module: `banked_file_mem`

## Requirements
- R1: After reset the bank register output `bsr_q` is 0.
- R2: When `bsr_load` is high at a rising clock edge, `bsr_q` takes `bsr_din`. When `bsr_load` is low, `bsr_q` keeps its value whatever `bsr_din` does.
- R3: With the port's banked bit at 0 and an offset in 00h–7Fh, the resolved address equals the offset (000h–07Fh).
- R4: With the banked bit at 0 and an offset in 80h–FFh, the resolved address is F00h plus the offset (F80h–FFFh). The port's hit flag is then 1.
- R5: With the banked bit at 1, the resolved address is `bsr_q` × 256 + offset.
- R6: On each port, the hit flag (`rd_sfr`, `wr_sfr`) is 1 exactly when that port's resolved address is F80h or above. It is combinational.
- R7: When `wr_en` is high at a rising edge and `wr_sfr` is 0, the byte `wr_data` is stored at the resolved write address. A read of that address returns it right after the edge.
- R8: A write whose resolved address is in the special-function region changes no stored byte. A read there returns 00h on `rd_data`.
- R9: When `wr_en` is low, no stored byte changes.
- R10: One physical byte is reached both ways. An access-window offset below 80h hits the same byte as bank 0 with the same offset, whatever value `bsr_q` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsr_load | input | 1 | Load strobe for the bank register |
| bsr_din | input | 4 | New bank value |
| bsr_q | output | 4 | Current bank value |
| rd_ofs | input | 8 | Read offset |
| rd_banked | input | 1 | Read mode: 0 access window, 1 banked |
| rd_data | output | 8 | Read byte (00h on a special-function hit) |
| rd_sfr | output | 1 | Read address is in the special-function region |
| wr_en | input | 1 | Write enable |
| wr_ofs | input | 8 | Write offset |
| wr_banked | input | 1 | Write mode: 0 access window, 1 banked |
| wr_data | input | 8 | Write byte |
| wr_sfr | output | 1 | Write address is in the special-function region |

## Verification
The memory is filled through banked writes to every offset of all 16 banks, each byte carrying an arithmetic function of its address. It is then read back in full through banked addressing, which tells a wrong bank concatenation apart from a wrong offset. All 256 access-window offsets are then read with an unrelated bank value loaded. This separates the low-half mapping from the high-half mapping, and both from any leak of the bank register into the window. A second pattern is written through the access window and read back through bank 0, to prove both paths reach one byte. Sweeps of writes aimed at the special-function region, and sweeps with the write enable held low, are each followed by a full reread. These catch any stray store.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
   typedef enum logic {
      MODE_WINDOW = 1'b0,
      MODE_BANKED = 1'b1
   } bfm_mode_e;
endpackage

// File: rtl/bfm_addr_resolve.sv
module bfm_addr_resolve
   import bfm_pkg::*;
#(
   parameter int BANK_W = 4,
   parameter int OFS_W  = 8,
   localparam int AW    = BANK_W + OFS_W
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [OFS_W-1:0]  ofs,
   input  logic              banked,
   output logic [AW-1:0]     addr,
   output logic              sfr
);
   bfm_mode_e mode;

   always_comb begin
      mode = bfm_mode_e'(banked);
      unique case (mode)
         MODE_BANKED: addr = {bank, ofs};
         default: begin
            if (ofs[OFS_W-1]) addr = {{BANK_W{1'b1}}, ofs};
            else              addr = {{BANK_W{1'b0}}, ofs};
         end
      endcase
      // top half of the last bank is the peripheral region
      sfr = &addr[AW-1:OFS_W-1];
   end
endmodule

// File: rtl/bfm_bank_reg.sv
module bfm_bank_reg #(
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BANK_W-1:0] din,
   output logic [BANK_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end

   p_load_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(din));
   p_hold_without_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/bfm_ram.sv
module bfm_ram #(
   parameter int DATA_W = 8,
   parameter int AW     = 12,
   parameter int DEPTH  = 3968
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     raddr,
   input  logic              rd_ext,
   output logic [DATA_W-1:0] rdata,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic              wr_ext,
   input  logic [DATA_W-1:0] wdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   if (DEPTH > (1 << AW)) begin : g_bad_depth
      $fatal(1, "bfm_ram: DEPTH exceeds address range");
   end

   always_ff @(posedge clk) begin
      if (we && !wr_ext) mem[waddr] <= wdata;
   end

   always_comb begin
      if (rd_ext) rdata = '0;
      else        rdata = mem[raddr];
   end

   p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wr_ext) |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/banked_file_mem.sv
module banked_file_mem #(
   parameter int BANK_W = 4,
   parameter int OFS_W  = 8,
   parameter int DATA_W = 8,
   localparam int AW    = BANK_W + OFS_W,
   localparam int HALF  = 1 << (OFS_W - 1),
   localparam int DEPTH = (1 << AW) - HALF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bsr_load,
   input  logic [BANK_W-1:0] bsr_din,
   output logic [BANK_W-1:0] bsr_q,
   input  logic [OFS_W-1:0]  rd_ofs,
   input  logic              rd_banked,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_sfr,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  wr_ofs,
   input  logic              wr_banked,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_sfr
);
   if (BANK_W < 1 || OFS_W < 2 || DATA_W < 1) begin : g_bad_param
      $fatal(1, "banked_file_mem: BANK_W>=1, OFS_W>=2, DATA_W>=1 required");
   end

   logic [AW-1:0] rd_addr;
   logic [AW-1:0] wr_addr;

   bfm_bank_reg #(.BANK_W(BANK_W)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .load (bsr_load),
      .din  (bsr_din),
      .q    (bsr_q)
   );

   bfm_addr_resolve #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_rd_res (
      .bank  (bsr_q),
      .ofs   (rd_ofs),
      .banked(rd_banked),
      .addr  (rd_addr),
      .sfr   (rd_sfr)
   );

   bfm_addr_resolve #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_wr_res (
      .bank  (bsr_q),
      .ofs   (wr_ofs),
      .banked(wr_banked),
      .addr  (wr_addr),
      .sfr   (wr_sfr)
   );

   bfm_ram #(.DATA_W(DATA_W), .AW(AW), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .raddr (rd_addr),
      .rd_ext(rd_sfr),
      .rdata (rd_data),
      .we    (wr_en),
      .waddr (wr_addr),
      .wr_ext(wr_sfr),
      .wdata (wr_data)
   );

   p_window_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_banked && !rd_ofs[OFS_W-1]) |-> !rd_sfr);
   p_window_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_banked && wr_ofs[OFS_W-1]) |-> wr_sfr);
   p_last_bank_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_banked && (&bsr_q) && rd_ofs[OFS_W-1]) |-> rd_sfr);
   p_sfr_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sfr |-> rd_data == '0);
endmodule

// File: tb/banked_file_mem_test.sv
module banked_file_mem_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bsr_load = 1'b0;
   logic [3:0] bsr_din = '0;
   logic [3:0] bsr_q;
   logic [7:0] rd_ofs = '0;
   logic       rd_banked = 1'b0;
   logic [7:0] rd_data;
   logic       rd_sfr;
   logic       wr_en = 1'b0;
   logic [7:0] wr_ofs = '0;
   logic       wr_banked = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_sfr;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [7:0] model [4096];

   always #5 clk = ~clk;

   banked_file_mem uut (
      .clk(clk), .rst_n(rst_n),
      .bsr_load(bsr_load), .bsr_din(bsr_din), .bsr_q(bsr_q),
      .rd_ofs(rd_ofs), .rd_banked(rd_banked), .rd_data(rd_data), .rd_sfr(rd_sfr),
      .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_banked(wr_banked), .wr_data(wr_data),
      .wr_sfr(wr_sfr)
   );

   function automatic int resolve(bit banked, int bank, int ofs);
      if (banked) return bank * 256 + ofs;
      if (ofs < 128) return ofs;
      return 3840 + ofs;
   endfunction

   function automatic logic [7:0] pat_a(int a);
      return 8'((a * 37 + 11) % 256);
   endfunction

   function automatic logic [7:0] pat_b(int a);
      return 8'(a % 256) ^ 8'((a / 16) % 256) ^ 8'h5A;
   endfunction

   task automatic check(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic set_bank(int b);
      @(negedge clk);
      bsr_load = 1'b1;
      bsr_din  = 4'(b);
      @(negedge clk);
      bsr_load = 1'b0;
      #1 check("R2 bank load", int'(bsr_q), b);
   endtask

   task automatic do_write(bit banked, int ofs, logic [7:0] d, bit en, string req);
      int a;
      bit s;
      @(negedge clk);
      wr_en = en;
      wr_banked = banked;
      wr_ofs = 8'(ofs);
      wr_data = d;
      a = resolve(banked, int'(bsr_q), ofs);
      s = (a >= 3968);
      #1 check({req, " wr_sfr"}, int'(wr_sfr), int'(s));
      if (en && !s) model[a] = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic do_read(bit banked, int ofs, string req);
      int a;
      bit s;
      rd_banked = banked;
      rd_ofs = 8'(ofs);
      a = resolve(banked, int'(bsr_q), ofs);
      s = (a >= 3968);
      #1;
      check({req, " rd_sfr"}, int'(rd_sfr), int'(s));
      check({req, " rd_data"}, int'(rd_data), s ? 0 : int'(model[a]));
   endtask

   task automatic read_all_banked(string req);
      for (int b = 0; b < 16; b++) begin
         set_bank(b);
         for (int o = 0; o < 256; o++) do_read(1'b1, o, req);
      end
   endtask

   initial begin
      #20;
      check("R1 bank reset", int'(bsr_q), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1 check("R1 bank after release", int'(bsr_q), 0);

      // fill every location through banked writes
      for (int b = 0; b < 16; b++) begin
         set_bank(b);
         for (int o = 0; o < 256; o++)
            do_write(1'b1, o, pat_a(b * 256 + o), 1'b1, "R5 R7 R6");
      end
      read_all_banked("R5 R7 R6");

      // window reads with an unrelated bank loaded: R3 R4 R6
      set_bank(7);
      for (int o = 0; o < 256; o++) do_read(1'b0, o, "R3 R4 window");

      // window writes of a second pattern, checked through bank 0: R10
      set_bank(9);
      for (int o = 0; o < 128; o++) do_write(1'b0, o, pat_b(o), 1'b1, "R10 R3");
      set_bank(0);
      for (int o = 0; o < 256; o++) do_read(1'b1, o, "R10 bank0");

      // writes into the peripheral region, then full reread: R8
      for (int o = 128; o < 256; o++) do_write(1'b0, o, 8'hA5, 1'b1, "R8 window");
      set_bank(15);
      for (int o = 128; o < 256; o++) do_write(1'b1, o, 8'h3C, 1'b1, "R8 banked");
      read_all_banked("R8 reread");

      // writes with the enable low: R9
      set_bank(3);
      for (int o = 0; o < 256; o++) do_write(1'b1, o, ~pat_a(o), 1'b0, "R9");
      for (int o = 0; o < 128; o++) do_write(1'b0, o, 8'hFF, 1'b0, "R9 window");
      for (int o = 0; o < 256; o++) do_read(1'b1, o, "R9 bank3");
      set_bank(0);
      for (int o = 0; o < 128; o++) do_read(1'b1, o, "R9 bank0");

      // R2: data changes without load do not move the bank
      for (int v = 0; v < 16; v++) begin
         @(negedge clk);
         bsr_din = 4'(v);
         @(negedge clk);
         #1 check("R2 hold", int'(bsr_q), 0);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1900000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule